// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block is the configuration port of a frequency synthesizer. A host drives three pins: a serial clock, a data line and a latch strobe. With the strobe low, each rising serial clock edge shifts one data bit into a 26-bit shift register, most significant bit first. The host then raises the strobe briefly. When the strobe falls, the word is committed, provided exactly 26 bits arrived since the previous strobe fall. The two lowest bits of the word pick one of four 24-bit holding registers. The upper 24 bits are written into that register.

All three pins are sampled by the system clock through synchronisers, so the rest of the logic runs in one clock domain. The four registers drive parallel outputs to the synthesizer core:

- Two registers hold frequency settings. The core must apply them as a pair, so an update strobe fires only after both have been written since the previous strobe.
- One bit of the calibration register, word bit 20, acts as a start control. Each 0-to-1 transition of that bit produces a one-cycle start pulse.

Top module: `serial_cfg_loader`

## Requirements
- R1: Word bits enter MSB first, one per rising edge of `ser_clk` seen while `ser_le` is low. Rising edges of `ser_clk` while `ser_le` is high are not counted and do not shift.
- R2: On commit, word bits [1:0] select the target and word bits [25:2] replace its contents. The selection is: 0 = `mode_word`, 1 = `cal_word`, 2 = `freq_a_word`, 3 = `freq_b_word`. At most one register changes per system clock cycle.
- R3: A falling edge of `ser_le` commits the word only when exactly 26 counted edges arrived since the previous falling edge. With 0, 25 or 27 edges, no register changes and no strobe fires.
- R4: A committed word with address 0 or 1 leaves `freq_a_word` and `freq_b_word` unchanged and raises no `freq_update`.
- R5: `freq_update` is a one-cycle pulse. It is raised in the same cycle that the second of the two frequency registers takes its new value, once both have been written since the last pulse, in either order. Rewriting one frequency register alone does not raise it.
- R6: `cal_start` is a one-cycle pulse. It is raised one cycle after `cal_word[18]` (word bit 20) changes from 0 to 1. Writes that leave the bit at 1, or clear it, raise no pulse.
- R7: While `rst_n` is low, all four registers clear to zero, both strobes stay low, and any pending half of a frequency pair is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_le | input | 1 | Latch strobe; low while shifting, its fall commits |
| ser_dat | input | 1 | Serial data, MSB first |
| mode_word | output | 24 | Operation mode register (address 0) |
| cal_word | output | 24 | Calibration control register (address 1) |
| freq_a_word | output | 24 | First frequency register (address 2) |
| freq_b_word | output | 24 | Second frequency register (address 3) |
| freq_update | output | 1 | One-cycle pulse when a frequency pair is complete |
| cal_start | output | 1 | One-cycle pulse on a rising calibration enable bit |

## Verification
The bench builds the block with its defaults: a two-stage pin synchroniser and the 26-bit word with a 2-bit address. The host pins are paced at four system cycles per phase, so every serial edge survives the synchroniser. This pacing makes it possible to place extra clock edges inside the strobe-high window and to send short, long and empty frames. The vectors mix pair completion in both orders, repeated halves, calibration bit transitions and a reset that lands between the two frequency halves.

// File: rtl/scl_pkg.sv
// Shared constants and types for the serial configuration loader.
// Assumes one 26-bit word format with a 2-bit address in the LSBs.
package scl_pkg;
    localparam int WORD_W     = 26;
    localparam int ADDR_W     = 2;
    localparam int REG_W      = WORD_W - ADDR_W;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(WORD_W + 2);
    // Calibration start control: word bit 20 lands at register bit 18.
    localparam int CAL_EN_POS = 20 - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_CAL    = 2'd1,
        ADDR_FREQ_A = 2'd2,
        ADDR_FREQ_B = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/scl_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each pin is independent and held for several clk cycles.
module scl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
// Serial word receiver working on synchronised pins.
// Detects serial clock rises while the latch is low, shifts data MSB first,
// and on a latch fall reports the word only when exactly WORD_W bits came in.
module scl_shifter
    import scl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              le_s,
    input  logic              dat_s,
    output logic              word_vld,
    output logic [ADDR_W-1:0] word_addr,
    output logic [REG_W-1:0]  word_data
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic              sclk_q, le_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              shift_en, le_fall;

    assign shift_en = sclk_s & ~sclk_q & ~le_s;
    assign le_fall  = le_q & ~le_s;

    // Remember the previous pin samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            le_q   <= le_s;
        end
    end

    // Shift one bit in per gated serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[WORD_W-2:0], dat_s};
    end

    // Count bits in the frame (saturating) and judge the frame at latch fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= le_fall && (cnt_q == CNT_FULL);
            if (le_fall)                           cnt_q <= '0;
            else if (shift_en && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign word_addr = shreg_q[ADDR_W-1:0];
    assign word_data = shreg_q[WORD_W-1:ADDR_W];
endmodule

// File: rtl/scl_regbank.sv
// Bank of addressed holding registers, one per address value.
// Assumes at most one write per cycle.
module scl_regbank
    import scl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [REG_W-1:0]                   wr_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]     regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] r_q;
        // Load this register when the committed word addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   r_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))      r_q <= wr_data;
        end
        assign regs[g] = r_q;
    end
endmodule

// File: rtl/scl_strobes.sv
// Side-effect strobes: frequency pair completion and calibration start.
// Assumes the calibration bit comes from the register bank output.
module scl_strobes
    import scl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cal_bit,
    output logic              freq_update,
    output logic              cal_start
);
    logic pend_a_q, pend_b_q, cal_q;
    logic next_a, next_b, pair_done;

    assign next_a    = pend_a_q | (wr_en && wr_addr == ADDR_FREQ_A);
    assign next_b    = pend_b_q | (wr_en && wr_addr == ADDR_FREQ_B);
    assign pair_done = next_a & next_b;

    // Track which frequency halves arrived and pulse when both are in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a_q    <= 1'b0;
            pend_b_q    <= 1'b0;
            freq_update <= 1'b0;
        end else begin
            freq_update <= pair_done;
            pend_a_q    <= next_a & ~pair_done;
            pend_b_q    <= next_b & ~pair_done;
        end
    end

    // Pulse once on each rising transition of the calibration enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q     <= 1'b0;
            cal_start <= 1'b0;
        end else begin
            cal_q     <= cal_bit;
            cal_start <= cal_bit & ~cal_q;
        end
    end
endmodule

// File: rtl/serial_cfg_loader.sv
// Top of the serial configuration loader.
// Synchronises the host pins into clk, receives addressed words, holds four
// registers and raises the frequency and calibration strobes.
// Assumes each host pin phase lasts at least SYNC_STAGES + 2 clk cycles.
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_le,
    input  logic             ser_dat,
    output logic [REG_W-1:0] mode_word,
    output logic [REG_W-1:0] cal_word,
    output logic [REG_W-1:0] freq_a_word,
    output logic [REG_W-1:0] freq_b_word,
    output logic             freq_update,
    output logic             cal_start
);
    logic [2:0]                       pins_s;
    logic                             word_vld;
    logic [ADDR_W-1:0]                word_addr;
    logic [REG_W-1:0]                 word_data;
    logic [NUM_REGS-1:0][REG_W-1:0]   regs;

    scl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_clk, ser_le, ser_dat}),
        .dout  (pins_s)
    );

    scl_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .le_s      (pins_s[1]),
        .dat_s     (pins_s[0]),
        .word_vld  (word_vld),
        .word_addr (word_addr),
        .word_data (word_data)
    );

    scl_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_vld),
        .wr_addr (word_addr),
        .wr_data (word_data),
        .regs    (regs)
    );

    scl_strobes u_strb (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (word_vld),
        .wr_addr     (word_addr),
        .cal_bit     (regs[ADDR_CAL][CAL_EN_POS]),
        .freq_update (freq_update),
        .cal_start   (cal_start)
    );

    assign mode_word   = regs[ADDR_MODE];
    assign cal_word    = regs[ADDR_CAL];
    assign freq_a_word = regs[ADDR_FREQ_A];
    assign freq_b_word = regs[ADDR_FREQ_B];
endmodule

// File: rtl/scl_checker.sv
// Assertion checker for serial_cfg_loader, attached with bind below.
module scl_checker
    import scl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic [ADDR_W-1:0] word_addr,
    input logic [REG_W-1:0]  mode_word,
    input logic [REG_W-1:0]  cal_word,
    input logic [REG_W-1:0]  freq_a_word,
    input logic [REG_W-1:0]  freq_b_word,
    input logic              freq_update,
    input logic              cal_start
);
    // R2: no two registers change in the same cycle.
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_word != $past(mode_word), cal_word != $past(cal_word),
                    freq_a_word != $past(freq_a_word),
                    freq_b_word != $past(freq_b_word)}) <= 1);

    // R4: a non-frequency commit leaves the frequency state alone.
    a_r4_freq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !word_addr[1]) |=>
            ($stable(freq_a_word) && $stable(freq_b_word) && !freq_update));

    // R5: the frequency strobe lasts one cycle.
    a_r5_update_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        freq_update |=> !freq_update);

    // R6: the calibration pulse lasts one cycle and follows a 0-to-1 bit.
    a_r6_cal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);
    a_r6_cal_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> (cal_word[CAL_EN_POS] && !$past(cal_word[CAL_EN_POS], 2)));

    // R7: leaving reset, registers and strobes are clear.
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_word == '0 && cal_word == '0 && freq_a_word == '0
                          && freq_b_word == '0 && !freq_update && !cal_start));
endmodule

bind serial_cfg_loader scl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_vld    (word_vld),
    .word_addr   (word_addr),
    .mode_word   (mode_word),
    .cal_word    (cal_word),
    .freq_a_word (freq_a_word),
    .freq_b_word (freq_b_word),
    .freq_update (freq_update),
    .cal_start   (cal_start)
);

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
    import scl_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_le = 1'b0, ser_dat = 1'b0;
    logic [23:0] mode_word, cal_word, freq_a_word, freq_b_word;
    logic        freq_update, cal_start;

    serial_cfg_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_le(ser_le),
        .ser_dat(ser_dat), .mode_word(mode_word), .cal_word(cal_word),
        .freq_a_word(freq_a_word), .freq_b_word(freq_b_word),
        .freq_update(freq_update), .cal_start(cal_start)
    );

    // Vector: {bit count[5:0], strobe-high clocks[1:0], data[23:0], addr[1:0]}
    localparam logic [33:0] VEC [16] = '{
        {6'd26, 2'd0, 24'h0A5A5A, 2'd0},
        {6'd26, 2'd0, 24'h03FFFF, 2'd1},
        {6'd26, 2'd0, 24'hC3A5F0, 2'd2},
        {6'd26, 2'd0, 24'h5A0F33, 2'd0},
        {6'd26, 2'd0, 24'h1E2D3C, 2'd3},
        {6'd26, 2'd0, 24'h040001, 2'd1},
        {6'd26, 2'd0, 24'h040002, 2'd1},
        {6'd25, 2'd0, 24'hFFFFFF, 2'd3},
        {6'd27, 2'd0, 24'hABCDEF, 2'd2},
        {6'd26, 2'd0, 24'h765432, 2'd3},
        {6'd26, 2'd2, 24'h13579B, 2'd2},
        {6'd26, 2'd0, 24'h000000, 2'd1},
        {6'd26, 2'd0, 24'h7FFFFF, 2'd1},
        {6'd26, 2'd0, 24'h800001, 2'd2},
        {6'd26, 2'd0, 24'h8F00F1, 2'd2},
        {6'd26, 2'd1, 24'h3C3C3C, 2'd3}
    };

    int checks = 0, fails = 0;
    int freq_cnt = 0, cal_cnt = 0, freq_run = 0, cal_run = 0;
    int freq_wmax = 0, cal_wmax = 0;
    logic [23:0] exp_r [4];
    int  exp_f = 0, exp_c = 0;
    bit  pa = 0, pb = 0;
    bit  done = 0;

    // Count strobe pulses and their widths away from the active edge.
    always @(negedge clk) begin
        if (freq_update) begin
            if (freq_run == 0) freq_cnt++;
            freq_run++;
            if (freq_run > freq_wmax) freq_wmax = freq_run;
        end else freq_run = 0;
        if (cal_start) begin
            if (cal_run == 0) cal_cnt++;
            cal_run++;
            if (cal_run > cal_wmax) cal_wmax = cal_run;
        end else cal_run = 0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [25:0] w, input int nbits, input int hi);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = w[25 - (i % 26)];
            waitn(4); ser_clk = 1'b1;
            waitn(4); ser_clk = 1'b0;
        end
        waitn(4); ser_le = 1'b1;
        for (int j = 0; j < hi; j++) begin
            ser_dat = ~ser_dat;
            waitn(4); ser_clk = 1'b1;
            waitn(4); ser_clk = 1'b0;
        end
        waitn(4); ser_le = 1'b0;
        waitn(12);
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [25:0] w, input int nbits);
        logic old_cal;
        if (nbits != 26) return;
        old_cal = exp_r[1][18];
        exp_r[w[1:0]] = w[25:2];
        if (w[1:0] == 2'd2) pa = 1;
        if (w[1:0] == 2'd3) pb = 1;
        if (pa && pb) begin exp_f++; pa = 0; pb = 0; end
        if (w[1:0] == 2'd1 && w[20] && !old_cal) exp_c++;
    endtask

    task automatic check_all(input string rtag, input string ftag);
        chk(rtag, {8'd0, mode_word},   {8'd0, exp_r[0]});
        chk(rtag, {8'd0, cal_word},    {8'd0, exp_r[1]});
        chk(rtag, {8'd0, freq_a_word}, {8'd0, exp_r[2]});
        chk(rtag, {8'd0, freq_b_word}, {8'd0, exp_r[3]});
        chk(ftag, freq_cnt, exp_f);
        chk("R6", cal_cnt, exp_c);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) exp_r[k] = '0;
        waitn(5);
        // R7: reset state
        check_all("R7", "R7");
        chk("R7", {30'd0, freq_update, cal_start}, 32'd0);
        rst_n = 1'b1;
        waitn(3);

        for (int v = 0; v < 16; v++) begin
            logic [25:0] w;
            int nb, hi;
            string rt, ft;
            w  = {VEC[v][25:2], VEC[v][1:0]};
            nb = int'(VEC[v][33:28]);
            hi = int'(VEC[v][27:26]);
            send(w, nb, hi);
            model(w, nb);
            rt = (nb != 26) ? "R3" : (hi != 0) ? "R1" : "R2";
            ft = (nb != 26) ? "R3" : (w[1] == 1'b0) ? "R4" : "R5";
            check_all(rt, ft);
        end

        // R3: empty frame (strobe pulse with no clocks) changes nothing
        send(26'h3FFFFFF, 0, 0);
        check_all("R3", "R3");

        // R7: reset between the two frequency halves clears pending state
        send({24'h112233, 2'd2}, 26, 0);
        model({24'h112233, 2'd2}, 26);
        rst_n = 1'b0;
        waitn(3);
        for (int k = 0; k < 4; k++) exp_r[k] = '0;
        pa = 0; pb = 0;
        check_all("R7", "R7");
        rst_n = 1'b1;
        waitn(3);
        send({24'h445566, 2'd3}, 26, 0);
        model({24'h445566, 2'd3}, 26);
        check_all("R7", "R7");

        // R6: calibration bit set after reset yields a pulse
        send({24'h040000, 2'd1}, 26, 0);
        model({24'h040000, 2'd1}, 26);
        check_all("R6", "R5");

        // R5 and R6: strobes were exactly one cycle wide
        chk("R5", freq_wmax, 1);
        chk("R6", cal_wmax, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule